// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Flags

This block is a first-in-first-out buffer for 18-bit words that crosses between two unrelated clocks. Words are written on `wr_clk` and read on `rd_clk`. The two clocks may run at any ratio, and no input states which one is faster. The depth is a power-of-two parameter. Typical builds use 8192 or 16384 words, and the default of 1024 keeps elaboration light. Each side computes its own status from its own pointer and a two-flop synchronised Gray-coded copy of the other side's pointer. Because of this, a flag in the far domain may clear a few cycles late, but it never sets late.

Two timing modes are available, chosen by `fwft_sel` while master reset is held:

- **Standard mode:** `rd_flag` means empty and `wr_flag` means full. A read needs `rd_en`, and the word appears on `dout` after the next `rd_clk` edge.
- **Fall-through mode:** `rd_flag` means output-ready and `wr_flag` means input-ready. The oldest word is presented on `dout` without any read request, and `rd_en` consumes it.

Two resets are provided:

- **Master reset** (`mrst`) clears the contents and samples both mode selects.
- **Partial reset** (`prst`) clears the contents but keeps the offsets and the mode.

The two almost-flag offsets are held in a register that can be loaded in three ways: from a preset at master reset, in parallel over the data bus, or bit-serially. Retransmit rewinds reading to the first location. Output enable forces `dout` to zero.

The read side is controlled by a state machine with four states:

- `RS_BOOT` is the state after any reset. It moves to `RS_STD` in standard mode and to `RS_FW_EMPTY` in fall-through mode.
- `RS_STD` stays put. It fetches on `rd_en` when data is present and rewinds on `rexmit`.
- `RS_FW_EMPTY` fetches as soon as data is present and moves to `RS_FW_VALID`. On `rexmit` it rewinds and stays.
- `RS_FW_VALID` holds its word until `rd_en`. It then fetches the next word and stays, or returns to `RS_FW_EMPTY` if none is present. On `rexmit` it rewinds and returns to `RS_FW_EMPTY`.

Top module: `dcf_fifo`

## Requirements
- R1: Words are read out in the order they were written, each word complete. A pointer advances by at most one location per clock of its own domain.
- R2: While `mrst` is high across at least one edge of each clock, the block is emptied and samples `fwft_sel` (1 selects fall-through mode) and `off_sel`. `off_sel`=0 presets both offsets to 7 and `off_sel`=1 presets both to 63. After release in standard mode: `rd_flag`=1, `wr_flag`=0, `half_full`=0, `almost_full`=0, `almost_empty`=1, `dout`=0.
- R3: `prst` empties the block but keeps the programmed offsets and the selected timing mode.
- R4: In standard mode `rd_flag`=1 exactly when no unread word is visible to the read side, and `wr_flag`=1 when DEPTH words are stored. A cycle with `rd_en` high and data present puts the next word on `dout` after that `rd_clk` edge.
- R5: In fall-through mode `rd_flag`=1 while a valid word is on `dout`, and `wr_flag`=1 while space remains. The first word appears without `rd_en` and is held until `rd_en` is high at a `rd_clk` edge.
- R6: `half_full`=1 when the write side counts more than DEPTH/2 stored words.
- R7: A write while full and a read while empty are ignored and do not move either pointer.
- R8: `almost_empty`=1 when the read side counts at most the empty offset in words. `almost_full`=1 when the free space is at most the full offset.
- R9: A write-clock edge with `wr_en` and `cfg_ld` both high loads `din` bits [AW-1:0] into an offset instead of the memory. After any reset the first such load goes to the empty offset and the next to the full offset, alternating after that.
- R10: Each write-clock edge with `ser_en` high shifts `ser_in` into the offsets. After 2*AW edges, the first bit sent is bit 0 of the empty offset, bit AW is bit 0 of the full offset, and the last bit sent is the full offset's MSB.
- R11: A `rexmit` pulse on a `rd_clk` edge sets reading back to location 0. In standard mode the next read returns the first word written since reset. In fall-through mode that word reappears on `dout` by itself.
- R12: While `oe`=0, `dout` is zero. `oe` does not affect pointers or flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write clock |
| rd_clk | input | 1 | Read clock |
| mrst | input | 1 | Master reset, active high |
| prst | input | 1 | Partial reset, active high |
| fwft_sel | input | 1 | Timing mode select, sampled during master reset |
| off_sel | input | 1 | Preset offset select (0: 7, 1: 63), sampled during master reset |
| wr_en | input | 1 | Write request |
| cfg_ld | input | 1 | Redirects writes to the offset register |
| ser_en | input | 1 | Serial offset shift enable |
| ser_in | input | 1 | Serial offset data |
| din | input | DW | Write data |
| wr_flag | output | 1 | Full (standard) or input-ready (fall-through) |
| half_full | output | 1 | More than half the depth stored |
| almost_full | output | 1 | Free space at or below the full offset |
| rd_en | input | 1 | Read request |
| rexmit | input | 1 | Retransmit pulse |
| oe | input | 1 | Output enable |
| dout | output | DW | Read data, zero when `oe` is low |
| rd_flag | output | 1 | Empty (standard) or output-ready (fall-through) |
| almost_empty | output | 1 | Stored words at or below the empty offset |

## Verification
The bench fills the buffer to exactly DEPTH words and then pushes one more. A design that let that write through would overwrite the oldest word, and the full read-back would show one wrong word. It steps across the half-full, almost-full and almost-empty thresholds one word at a time, so an off-by-one comparison shows up as a flag that is one word early or late. It loads the offsets both serially and in parallel and then applies a partial reset. A design that cleared the offsets on partial reset, or shifted in the wrong bit order, would move the observed thresholds. Retransmit is exercised in both timing modes, where a design that forgot to re-arm the fall-through stage would leave `dout` stale or `rd_flag` low.

// File: rtl/dcf_pkg.sv
package dcf_pkg;

    typedef enum logic [1:0] {
        RS_BOOT,
        RS_STD,
        RS_FW_EMPTY,
        RS_FW_VALID
    } rd_state_t;

    function automatic logic [31:0] gray2bin(input logic [31:0] g);
        logic [31:0] b;
        b[31] = g[31];
        for (int i = 30; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

endpackage

// File: rtl/dcf_sync.sv
module dcf_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] pipe [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk or posedge rst) begin
                if (rst) pipe[s] <= '0;
                else     pipe[s] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or posedge rst) begin
                if (rst) pipe[s] <= '0;
                else     pipe[s] <= pipe[s-1];
            end
        end
    end

    assign q = pipe[STAGES-1];

endmodule

// File: rtl/dcf_offsets.sv
module dcf_offsets #(
    parameter int AW     = 10,
    parameter int OFF_LO = 7,
    parameter int OFF_HI = 63
) (
    input  logic          clk,
    input  logic          mrst,
    input  logic          rst_any,
    input  logic          off_sel,
    input  logic          wr_en,
    input  logic          cfg_ld,
    input  logic [AW-1:0] ld_val,
    input  logic          ser_en,
    input  logic          ser_in,
    output logic [AW-1:0] ae_off,
    output logic [AW-1:0] af_off
);

    logic [2*AW-1:0] shreg;
    logic            ld_hi;
    logic [AW-1:0]   preset;

    assign preset = off_sel ? AW'(OFF_HI) : AW'(OFF_LO);

    always_ff @(posedge clk) begin
        if (mrst) begin
            shreg <= {preset, preset};
        end else if (ser_en) begin
            shreg <= {ser_in, shreg[2*AW-1:1]};
        end else if (cfg_ld && wr_en) begin
            if (ld_hi) shreg[2*AW-1:AW] <= ld_val;
            else       shreg[AW-1:0]    <= ld_val;
        end
    end

    always_ff @(posedge clk or posedge rst_any) begin
        if (rst_any)                          ld_hi <= 1'b0;
        else if (cfg_ld && wr_en && !ser_en)  ld_hi <= ~ld_hi;
    end

    assign ae_off = shreg[AW-1:0];
    assign af_off = shreg[2*AW-1:AW];

endmodule

// File: rtl/dcf_rd_ctrl.sv
module dcf_rd_ctrl
    import dcf_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic fwft,
    input  logic rd_en,
    input  logic rexmit,
    input  logic nempty,
    output logic fetch,
    output logic rewind,
    output logic out_valid
);

    rd_state_t state, state_nx;

    always_ff @(posedge clk or posedge rst) begin
        if (rst) state <= RS_BOOT;
        else     state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            RS_BOOT:     state_nx = fwft ? RS_FW_EMPTY : RS_STD;
            RS_STD:      state_nx = RS_STD;
            RS_FW_EMPTY: if (!rexmit && nempty) state_nx = RS_FW_VALID;
            RS_FW_VALID: if (rexmit || (rd_en && !nempty)) state_nx = RS_FW_EMPTY;
            default:     state_nx = RS_BOOT;
        endcase
    end

    always_comb begin
        fetch     = 1'b0;
        rewind    = 1'b0;
        out_valid = 1'b0;
        unique case (state)
            RS_BOOT: ;
            RS_STD: begin
                rewind = rexmit;
                fetch  = !rexmit && rd_en && nempty;
            end
            RS_FW_EMPTY: begin
                rewind = rexmit;
                fetch  = !rexmit && nempty;
            end
            RS_FW_VALID: begin
                out_valid = 1'b1;
                rewind    = rexmit;
                fetch     = !rexmit && rd_en && nempty;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/dcf_fifo.sv
module dcf_fifo
    import dcf_pkg::*;
#(
    parameter int DW     = 18,
    parameter int DEPTH  = 1024,
    parameter int OFF_LO = 7,
    parameter int OFF_HI = 63
) (
    input  logic          wr_clk,
    input  logic          rd_clk,
    input  logic          mrst,
    input  logic          prst,
    input  logic          fwft_sel,
    input  logic          off_sel,
    input  logic          wr_en,
    input  logic          cfg_ld,
    input  logic          ser_en,
    input  logic          ser_in,
    input  logic [DW-1:0] din,
    output logic          wr_flag,
    output logic          half_full,
    output logic          almost_full,
    input  logic          rd_en,
    input  logic          rexmit,
    input  logic          oe,
    output logic [DW-1:0] dout,
    output logic          rd_flag,
    output logic          almost_empty
);

    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;

    logic          rst_any;
    logic          wr_mode, rd_mode;
    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] ae_off, af_off;

    assign rst_any = mrst | prst;

    always_ff @(posedge wr_clk) if (mrst) wr_mode <= fwft_sel;
    always_ff @(posedge rd_clk) if (mrst) rd_mode <= fwft_sel;

    dcf_offsets #(.AW(AW), .OFF_LO(OFF_LO), .OFF_HI(OFF_HI)) u_offsets (
        .clk(wr_clk), .mrst(mrst), .rst_any(rst_any), .off_sel(off_sel),
        .wr_en(wr_en), .cfg_ld(cfg_ld), .ld_val(din[AW-1:0]),
        .ser_en(ser_en), .ser_in(ser_in), .ae_off(ae_off), .af_off(af_off)
    );

    // write domain
    logic [PW-1:0] wptr_bin, wptr_gray, wptr_nx, rsync_gray, rsync_bin, wcount;
    logic          full, wr_go;

    dcf_sync #(.W(PW)) u_rsync (.clk(wr_clk), .rst(rst_any), .d(rptr_gray), .q(rsync_gray));

    assign rsync_bin = PW'(gray2bin(32'(rsync_gray)));
    assign wcount    = wptr_bin - rsync_bin;
    assign full      = (wcount == PW'(DEPTH));
    assign wr_go     = wr_en && !cfg_ld && !full;
    assign wptr_nx   = wptr_bin + PW'(wr_go);

    always_ff @(posedge wr_clk or posedge rst_any) begin
        if (rst_any) begin
            wptr_bin  <= '0;
            wptr_gray <= '0;
        end else begin
            wptr_bin  <= wptr_nx;
            wptr_gray <= wptr_nx ^ (wptr_nx >> 1);
        end
    end

    always_ff @(posedge wr_clk) begin
        if (wr_go) mem[wptr_bin[AW-1:0]] <= din;
    end

    assign half_full   = wcount > PW'(DEPTH / 2);
    assign almost_full = (PW'(DEPTH) - wcount) <= {1'b0, af_off};
    assign wr_flag     = wr_mode ? !full : full;

    // read domain
    logic [PW-1:0] rptr_bin, rptr_gray, rptr_nx, wsync_gray, wsync_bin, rcount;
    logic          nempty, fetch, rewind, out_valid;
    logic [DW-1:0] dout_q;

    dcf_sync #(.W(PW)) u_wsync (.clk(rd_clk), .rst(rst_any), .d(wptr_gray), .q(wsync_gray));

    assign wsync_bin = PW'(gray2bin(32'(wsync_gray)));
    assign nempty    = (wsync_bin != rptr_bin);

    dcf_rd_ctrl u_rd_ctrl (
        .clk(rd_clk), .rst(rst_any), .fwft(rd_mode), .rd_en(rd_en),
        .rexmit(rexmit), .nempty(nempty), .fetch(fetch), .rewind(rewind),
        .out_valid(out_valid)
    );

    assign rptr_nx = rewind ? '0 : (rptr_bin + PW'(fetch));

    always_ff @(posedge rd_clk or posedge rst_any) begin
        if (rst_any) begin
            rptr_bin  <= '0;
            rptr_gray <= '0;
        end else begin
            rptr_bin  <= rptr_nx;
            rptr_gray <= rptr_nx ^ (rptr_nx >> 1);
        end
    end

    always_ff @(posedge rd_clk or posedge rst_any) begin
        if (rst_any)    dout_q <= '0;
        else if (fetch) dout_q <= mem[rptr_bin[AW-1:0]];
    end

    assign rcount       = wsync_bin - rptr_bin + PW'(out_valid);
    assign almost_empty = rcount <= {1'b0, ae_off};
    assign rd_flag      = rd_mode ? out_valid : !nempty;
    assign dout         = oe ? dout_q : '0;

endmodule

// File: rtl/dcf_fifo_chk.sv
module dcf_fifo_chk #(
    parameter int DW = 18,
    parameter int PW = 11
) (
    input logic          wr_clk,
    input logic          rd_clk,
    input logic          rst_any,
    input logic          wr_en,
    input logic          full,
    input logic [PW-1:0] wptr_bin,
    input logic          half_full,
    input logic          almost_full,
    input logic          rd_mode,
    input logic          rd_en,
    input logic          rexmit,
    input logic          rd_flag,
    input logic [PW-1:0] rptr_bin,
    input logic [DW-1:0] dout_q
);

    p_no_overflow_r7: assert property (@(posedge wr_clk) disable iff (rst_any)
        (wr_en && full) |=> $stable(wptr_bin));

    p_no_underflow_r7: assert property (@(posedge rd_clk) disable iff (rst_any)
        (!rd_mode && rd_en && rd_flag && !rexmit) |=> $stable(rptr_bin));

    p_full_implies_flags_r6: assert property (@(posedge wr_clk) disable iff (rst_any)
        full |-> (half_full && almost_full));

    p_fall_hold_r5: assert property (@(posedge rd_clk) disable iff (rst_any)
        (rd_mode && rd_flag && !rd_en && !rexmit) |=> (rd_flag && $stable(dout_q)));

    p_wr_step_r1: assert property (@(posedge wr_clk) disable iff (rst_any)
        1'b1 |=> ((wptr_bin == $past(wptr_bin)) || (wptr_bin == $past(wptr_bin) + PW'(1))));

endmodule

bind dcf_fifo dcf_fifo_chk #(.DW(DW), .PW(PW)) u_chk (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_any(rst_any), .wr_en(wr_en),
    .full(full), .wptr_bin(wptr_bin), .half_full(half_full),
    .almost_full(almost_full), .rd_mode(rd_mode), .rd_en(rd_en),
    .rexmit(rexmit), .rd_flag(rd_flag), .rptr_bin(rptr_bin), .dout_q(dout_q)
);

// File: tb/dcf_fifo_tb.sv
`timescale 1ns/100ps
module dcf_fifo_tb;

    localparam int  DW        = 18;
    localparam int  DEPTH     = 256;
    localparam real WR_PERIOD = 10.0;
    localparam real RD_PERIOD = 14.0;
    localparam int  WD_CYCLES = 150000;

    // {oe, data}
    localparam logic [DW:0] VEC [8] = '{
        {1'b1, 18'h00001}, {1'b1, 18'h2AAAA}, {1'b0, 18'h15555}, {1'b1, 18'h3FFFF},
        {1'b1, 18'h00000}, {1'b0, 18'h12345}, {1'b1, 18'h20001}, {1'b1, 18'h0F0F0}
    };

    logic wr_clk = 1'b0, rd_clk = 1'b0;
    logic mrst = 1'b1, prst = 1'b0, fwft_sel = 1'b0, off_sel = 1'b0;
    logic wr_en = 1'b0, cfg_ld = 1'b0, ser_en = 1'b0, ser_in = 1'b0;
    logic rd_en = 1'b0, rexmit = 1'b0, oe = 1'b1;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] dout;
    logic wr_flag, half_full, almost_full, rd_flag, almost_empty;

    int checks = 0;
    int fails  = 0;

    always #(WR_PERIOD / 2) wr_clk = ~wr_clk;
    initial begin
        #0.3;
        forever #(RD_PERIOD / 2) rd_clk = ~rd_clk;
    end

    dcf_fifo #(.DW(DW), .DEPTH(DEPTH)) u_dut (
        .wr_clk(wr_clk), .rd_clk(rd_clk), .mrst(mrst), .prst(prst),
        .fwft_sel(fwft_sel), .off_sel(off_sel), .wr_en(wr_en), .cfg_ld(cfg_ld),
        .ser_en(ser_en), .ser_in(ser_in), .din(din), .wr_flag(wr_flag),
        .half_full(half_full), .almost_full(almost_full), .rd_en(rd_en),
        .rexmit(rexmit), .oe(oe), .dout(dout), .rd_flag(rd_flag),
        .almost_empty(almost_empty)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_mrst(input logic f, input logic o);
        @(negedge wr_clk);
        fwft_sel = f; off_sel = o; mrst = 1'b1;
        repeat (3) @(negedge wr_clk);
        repeat (3) @(negedge rd_clk);
        @(negedge wr_clk) mrst = 1'b0;
        repeat (3) @(negedge rd_clk);
    endtask

    task automatic do_prst();
        @(negedge wr_clk) prst = 1'b1;
        repeat (3) @(negedge rd_clk);
        @(negedge wr_clk) prst = 1'b0;
        repeat (3) @(negedge rd_clk);
    endtask

    task automatic wr(input logic [DW-1:0] d);
        @(negedge wr_clk);
        wr_en = 1'b1; din = d;
        @(negedge wr_clk);
        wr_en = 1'b0;
    endtask

    task automatic rd();
        @(negedge rd_clk) rd_en = 1'b1;
        @(negedge rd_clk) rd_en = 1'b0;
    endtask

    task automatic settle();
        repeat (6) @(negedge rd_clk);
        repeat (2) @(negedge wr_clk);
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge wr_clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int errs;
        logic [15:0] sbits;

        // reset state, standard mode, presets at 7
        do_mrst(1'b0, 1'b0);
        check("R2 rd_flag after master reset", rd_flag, 1);
        check("R2 wr_flag after master reset", wr_flag, 0);
        check("R2 half_full after master reset", half_full, 0);
        check("R2 almost_full after master reset", almost_full, 0);
        check("R2 almost_empty after master reset", almost_empty, 1);
        check("R2 dout after master reset", dout, 0);

        // vector table: write all, then read with oe per entry
        for (int i = 0; i < 7; i++) wr(VEC[i][DW-1:0]);
        settle();
        check("R8 almost_empty at 7 words", almost_empty, 1);
        wr(VEC[7][DW-1:0]);
        settle();
        check("R8 almost_empty at 8 words", almost_empty, 0);
        check("R4 rd_flag with data", rd_flag, 0);
        for (int i = 0; i < 8; i++) begin
            oe = VEC[i][DW];
            rd();
            check($sformatf("R1 R12 table entry %0d", i), dout,
                  VEC[i][DW] ? 32'(VEC[i][DW-1:0]) : 32'h0);
        end
        oe = 1'b1;
        check("R4 rd_flag empty after draining", rd_flag, 1);

        // read while empty is ignored
        rd();
        check("R7 empty read keeps dout", dout, 32'h0F0F0);
        wr(18'h2A5A);
        settle();
        rd();
        check("R7 read pointer unmoved by empty read", dout, 32'h2A5A);

        // fill to full, overflow write, read back
        do_prst();
        for (int i = 0; i < DEPTH; i++) begin
            wr(DW'(i));
            if (i == 127) check("R6 half_full at 128 words", half_full, 0);
            if (i == 128) check("R6 half_full at 129 words", half_full, 1);
            if (i == 247) check("R8 almost_full at 248 words", almost_full, 0);
            if (i == 248) check("R8 almost_full at 249 words", almost_full, 1);
        end
        check("R4 wr_flag full", wr_flag, 1);
        wr(18'h3FFFF);
        check("R7 wr_flag still full after overflow", wr_flag, 1);
        settle();
        errs = 0;
        for (int i = 0; i < DEPTH; i++) begin
            rd();
            if (dout !== DW'(i)) errs++;
        end
        check("R1 R7 full read-back mismatches", errs, 0);
        check("R4 rd_flag after full drain", rd_flag, 1);

        // parallel load: empty offset 3, full offset 5, then partial reset
        @(negedge wr_clk);
        wr_en = 1'b1; cfg_ld = 1'b1; din = 18'd3;
        @(negedge wr_clk) din = 18'd5;
        @(negedge wr_clk);
        wr_en = 1'b0; cfg_ld = 1'b0;
        do_prst();
        check("R3 partial reset empties", rd_flag, 1);
        for (int i = 0; i < 3; i++) wr(18'h1);
        settle();
        check("R9 almost_empty at 3 words, offset 3", almost_empty, 1);
        wr(18'h1);
        settle();
        check("R9 R3 almost_empty at 4 words, offset kept", almost_empty, 0);
        check("R3 standard mode kept", rd_flag, 0);

        // serial load: empty offset 10, full offset 20
        sbits = {8'd20, 8'd10};
        for (int i = 0; i < 16; i++) begin
            @(negedge wr_clk);
            ser_en = 1'b1; ser_in = sbits[i];
        end
        @(negedge wr_clk) ser_en = 1'b0;
        do_prst();
        for (int i = 0; i < 10; i++) wr(18'h2);
        settle();
        check("R10 almost_empty at 10 words", almost_empty, 1);
        wr(18'h2);
        settle();
        check("R10 almost_empty at 11 words", almost_empty, 0);
        for (int i = 11; i < 235; i++) wr(18'h2);
        check("R10 almost_full at 235 words", almost_full, 0);
        wr(18'h2);
        check("R10 almost_full at 236 words", almost_full, 1);

        // retransmit, standard mode
        do_prst();
        for (int i = 0; i < 5; i++) wr(DW'(18'h100 + i));
        settle();
        rd(); rd(); rd();
        check("R4 third read", dout, 32'h102);
        @(negedge rd_clk) rexmit = 1'b1;
        @(negedge rd_clk) rexmit = 1'b0;
        rd();
        check("R11 standard retransmit returns first word", dout, 32'h100);

        // master reset restores preset 63
        do_mrst(1'b0, 1'b1);
        for (int i = 0; i < 63; i++) wr(18'h3);
        settle();
        check("R2 almost_empty at 63 words, preset 63", almost_empty, 1);
        wr(18'h3);
        settle();
        check("R2 almost_empty at 64 words, preset 63", almost_empty, 0);

        // fall-through mode
        do_mrst(1'b1, 1'b0);
        check("R5 output-ready low after reset", rd_flag, 0);
        check("R5 input-ready high after reset", wr_flag, 1);
        wr(18'h11111);
        settle();
        check("R5 first word ready without read", rd_flag, 1);
        check("R5 first word on dout", dout, 32'h11111);
        wr(18'h22222);
        settle();
        check("R5 word held without rd_en", dout, 32'h11111);
        rd();
        check("R5 rd_en advances to next word", dout, 32'h22222);
        rd();
        check("R5 output-ready low when drained", rd_flag, 0);
        @(negedge rd_clk) rexmit = 1'b1;
        @(negedge rd_clk) rexmit = 1'b0;
        settle();
        check("R11 fall-through retransmit ready", rd_flag, 1);
        check("R11 fall-through retransmit first word", dout, 32'h11111);
        oe = 1'b0;
        #1;
        check("R12 oe low forces zero", dout, 0);
        check("R12 oe low keeps ready", rd_flag, 1);
        oe = 1'b1;
        #1;
        check("R12 word restored with oe high", dout, 32'h11111);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule